// File: doc/BRIEF.md
# Four-Phase Host Access Sequencer

This block is the host-side access controller for a multi-channel serial peripheral. It sits on the system clock and watches an active-low chip enable and a write/read-not line from the host. Every register access it grants runs as a fixed sequence of four clock phases, C1 to C4. In the third phase it opens the read-data latch for read accesses. In the last phase it drives an active-low data acknowledge and, for writes, a single-clock internal write strobe.

A mode input picks between two ways of handling a long chip-enable assertion. In single mode the host gets one access for each falling edge of chip enable. In burst mode a new four-phase access begins every four clocks for as long as chip enable stays low. Chip enable and the direction line first pass through a two-stage synchronizer. Phase C1 begins on the clock after the synchronized enable is seen low. Releasing chip enable ends the current access at once, so a pulse that is too short never writes.

Top module: `host_bus_sequencer`

## Requirements
- R1: With `cs_n` driven low just before clock edge k, the sequencer is in phase C1 after edge k+2 and in phase C4 after edge k+5. The two synchronizer stages account for the extra delay.
- R2: `ack_n` is low for exactly one clock per completed access, during phase C4 (after edge k+5 for the first access), and is high at all other times.
- R3: When `burst_mode` is 0, at most one access completes per low period of `cs_n`, however long `cs_n` stays low.
- R4: When `burst_mode` is 1 and `cs_n` stays low, a new access starts right after each C4. With `cs_n` low for L clocks, floor((L-1)/4) accesses complete.
- R5: When the synchronized chip enable goes high, the current access stops in that same clock. `ack_n`, `wr_stb` and `rd_le` go inactive and the sequencer returns to idle.
- R6: If `cs_n` is low for fewer than 5 clocks, no access completes. No `wr_stb` and no `ack_n` pulse is produced.
- R7: `wr_stb` is high for one clock, only in C4, and only for an access whose direction was write (`wr_rd_n` = 1) when C1 began.
- R8: `rd_le` is high for one clock, in C3, only for read accesses (`wr_rd_n` = 0). It therefore comes exactly one clock before that access's `ack_n` pulse.
- R9: While `rst_n` is low at a clock edge, the sequencer and the synchronizer return to idle. After that edge `ack_n` = 1, `wr_stb` = 0 and `rd_le` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip enable from the host (asynchronous) |
| wr_rd_n | input | 1 | Access direction: 1 write, 0 read |
| burst_mode | input | 1 | 1 selects repeated accesses while enabled, 0 selects one access per enable |
| ack_n | output | 1 | Active-low data acknowledge, low in C4 |
| wr_stb | output | 1 | One-clock internal write strobe in C4 |
| rd_le | output | 1 | Read-data latch enable in C3 |

## Verification
On every clock, the embedded properties check the following. The acknowledge never lasts two clocks. Strobes appear only inside the acknowledged or latch phase of an access in the matching direction. A released enable always returns the sequencer to idle. A C4 in single mode is never followed directly by a new C1. Only the bench's scenarios can show the rest. These are the exact clock on which C1, C3 and C4 fall relative to the enable edge, and the number of completed accesses for a given enable length in each mode. They also cover short-pulse aborts at the 4 and 5 clock boundary and reset in the middle of an access.

// File: rtl/host_bus_seq_pkg.sv
// Package: shared state type for the host access sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package host_bus_seq_pkg;

    // Top-level sequencer state; the phase inside an access is a separate counter.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,   // waiting for chip enable
        SEQ_RUN  = 2'd1,   // inside an access, phase counter valid
        SEQ_HOLD = 2'd2    // access done in single mode, waiting for release
    } seq_state_t;

endpackage

// File: rtl/host_bus_sync.sv
// Module: multi-bit, multi-stage synchronizer for quasi-static host lines.
// Assumes: each bit is synchronized on its own; the bits must be stable
// around the edge where chip enable falls, so that they arrive together.
module host_bus_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw input into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d_in;
                end
            end else begin : g_next
                // Shift the value one stage further along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/host_bus_phase_fsm.sv
// Module: access phase sequencer.
// It counts NUM_PHASES clocks per access from the first clock where the
// synchronized enable is active. It loops or holds at the last phase depending
// on the mode, and aborts to idle whenever the enable goes away.
// Assumes: cs_act and wr_sync are already synchronous to clk.
module host_bus_phase_fsm
    import host_bus_seq_pkg::*;
#(
    parameter int NUM_PHASES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic wr_sync,
    input  logic burst_mode,
    output logic in_latch,
    output logic in_last,
    output logic dir_wr
);

    localparam int CW = (NUM_PHASES > 2) ? $clog2(NUM_PHASES) : 1;
    localparam logic [CW-1:0] LAST_PH  = CW'(NUM_PHASES - 1);
    localparam logic [CW-1:0] LATCH_PH = CW'(NUM_PHASES - 2);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          dir_q, dir_d;

    // Next-state: start, advance, restart or hold, and abort on release.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        dir_d   = dir_q;
        if (!cs_act) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    state_d = SEQ_RUN;
                    cnt_d   = '0;
                    dir_d   = wr_sync;
                end
                SEQ_RUN: begin
                    if (cnt_q == LAST_PH) begin
                        cnt_d = '0;
                        if (burst_mode) begin
                            state_d = SEQ_RUN;
                            dir_d   = wr_sync;
                        end else begin
                            state_d = SEQ_HOLD;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                SEQ_HOLD: state_d = SEQ_HOLD;
                default:  state_d = SEQ_IDLE;
            endcase
        end
    end

    // State, phase counter and direction registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            dir_q   <= dir_d;
        end
    end

    assign in_last  = (state_q == SEQ_RUN) && (cnt_q == LAST_PH);
    assign in_latch = (state_q == SEQ_RUN) && (cnt_q == LATCH_PH);
    assign dir_wr   = dir_q;

    // R5: a released enable always leaves the sequencer idle on the next clock.
    p_release_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state_q == SEQ_IDLE));

    // R3: in single mode the last phase never leads straight into a new C1.
    p_single_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_last && !burst_mode) |=> !(state_q == SEQ_RUN && cnt_q == '0));

    // R1: an access always begins from idle or from the last phase of the previous one.
    p_c1_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == SEQ_RUN) |-> ($past(state_q) == SEQ_IDLE));

endmodule

// File: rtl/host_bus_strobe_gen.sv
// Module: strobe and acknowledge decoder.
// It gates the phase flags with the live synchronized enable, so that a
// withdrawn enable silences every output in the same clock.
// Assumes: in_latch and in_last are never high together.
module host_bus_strobe_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic in_latch,
    input  logic in_last,
    input  logic dir_wr,
    output logic ack_n,
    output logic wr_stb,
    output logic rd_le
);

    logic live_last;
    logic live_latch;

    // Qualify the phase flags with the current enable.
    always_comb begin
        live_last  = in_last  && cs_act;
        live_latch = in_latch && cs_act;
    end

    // Drive the outputs from the qualified phases and the captured direction.
    always_comb begin
        ack_n  = !live_last;
        wr_stb = live_last  &&  dir_wr;
        rd_le  = live_latch && !dir_wr;
    end

    // R2: the acknowledge never lasts more than one clock.
    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |=> ack_n);

    // R7: a write strobe is only ever seen together with the acknowledge.
    p_wr_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !ack_n);

    // R8: the read latch enable is never shown during the acknowledge.
    p_rd_before_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_le |-> ack_n);

    // R6: no write strobe without a live enable.
    p_no_short_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> cs_act);

endmodule

// File: rtl/host_bus_sequencer.sv
// Module: top of the host access sequencer.
// It synchronizes chip enable and direction, then runs NUM_PHASES-clock
// accesses in single or burst mode and drives acknowledge and strobes.
// Assumes: wr_rd_n is valid no later than the falling edge of cs_n.
module host_bus_sequencer #(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_PHASES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_rd_n,
    input  logic burst_mode,
    output logic ack_n,
    output logic wr_stb,
    output logic rd_le
);

    logic [1:0] sync_out;
    logic       cs_act;
    logic       wr_sync;
    logic       in_latch;
    logic       in_last;
    logic       dir_wr;

    host_bus_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({cs_n, wr_rd_n}),
        .d_out (sync_out)
    );

    assign cs_act  = !sync_out[1];
    assign wr_sync = sync_out[0];

    host_bus_phase_fsm #(
        .NUM_PHASES (NUM_PHASES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .wr_sync    (wr_sync),
        .burst_mode (burst_mode),
        .in_latch   (in_latch),
        .in_last    (in_last),
        .dir_wr     (dir_wr)
    );

    host_bus_strobe_gen u_strb (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .in_latch (in_latch),
        .in_last  (in_last),
        .dir_wr   (dir_wr),
        .ack_n    (ack_n),
        .wr_stb   (wr_stb),
        .rd_le    (rd_le)
    );

    // R9: the clock after a reset edge shows an idle bus.
    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> (ack_n && !wr_stb && !rd_le));

endmodule

// File: tb/host_bus_sequencer_test.sv
module host_bus_sequencer_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic wr_rd_n = 1'b0;
    logic burst_mode = 1'b0;
    logic ack_n, wr_stb, rd_le;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    host_bus_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd_n(wr_rd_n),
        .burst_mode(burst_mode), .ack_n(ack_n), .wr_stb(wr_stb), .rd_le(rd_le)
    );

    // Vector: {burst, write, low clocks, ack count, rd_le count, wr_stb count}
    localparam int NVEC = 10;
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 7'd3,  4'd0, 4'd0, 4'd0},  // R6 short write
        {1'b0, 1'b1, 7'd4,  4'd0, 4'd0, 4'd0},  // R6 boundary
        {1'b0, 1'b1, 7'd5,  4'd1, 4'd0, 4'd1},  // R7 minimal write
        {1'b0, 1'b0, 7'd5,  4'd1, 4'd1, 4'd0},  // R8 minimal read
        {1'b0, 1'b1, 7'd20, 4'd1, 4'd0, 4'd1},  // R3 long single
        {1'b1, 1'b1, 7'd20, 4'd4, 4'd0, 4'd4},  // R4 burst write
        {1'b1, 1'b0, 7'd13, 4'd3, 4'd3, 4'd0},  // R4 burst read
        {1'b1, 1'b0, 7'd4,  4'd0, 4'd1, 4'd0},  // R5 cut at C3
        {1'b0, 1'b0, 7'd4,  4'd0, 4'd1, 4'd0},  // R5 cut at C3 single
        {1'b1, 1'b1, 7'd9,  4'd2, 4'd0, 4'd2}   // R4 burst, cut in C1
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 reset ack_n", int'(ack_n), 1);
        check("R9 reset wr_stb", int'(wr_stb), 0);
        check("R9 reset rd_le", int'(rd_le), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            int len, n_ack, n_rd, n_wr;
            len = int'(VEC[v][18:12]);
            n_ack = 0; n_rd = 0; n_wr = 0;
            burst_mode = VEC[v][20];
            wr_rd_n    = VEC[v][19];
            cs_n       = 1'b0;
            for (int c = 1; c <= len + 8; c++) begin
                @(negedge clk);
                if (!ack_n) n_ack++;
                if (rd_le)  n_rd++;
                if (wr_stb) n_wr++;
                if (c == len) cs_n = 1'b1;
            end
            check($sformatf("R2/R3/R4/R6 vec%0d ack count", v), n_ack, int'(VEC[v][11:8]));
            check($sformatf("R8 vec%0d rd_le count", v), n_rd, int'(VEC[v][7:4]));
            check($sformatf("R7 vec%0d wr_stb count", v), n_wr, int'(VEC[v][3:0]));
        end

        // R1/R2/R8: exact phase timing of a single read
        burst_mode = 1'b0;
        wr_rd_n = 1'b0;
        cs_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 rd_le in C3", int'(rd_le), 1);
        check("R1 ack_n high before C4", int'(ack_n), 1);
        @(negedge clk);
        check("R1 ack_n low in C4", int'(ack_n), 0);
        check("R8 rd_le off in C4", int'(rd_le), 0);
        @(negedge clk);
        check("R2 ack_n one clock", int'(ack_n), 1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: reset during C4 of a write
        wr_rd_n = 1'b1;
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R7 wr_stb in C4", int'(wr_stb), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid-access ack_n", int'(ack_n), 1);
        check("R9 mid-access wr_stb", int'(wr_stb), 0);
        cs_n = 1'b1;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R5: release during C4 in burst silences ack at once
        burst_mode = 1'b1;
        cs_n = 1'b0;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;             // last low clock before sync edge of C4
        @(negedge clk);
        check("R1 burst C4 ack_n", int'(ack_n), 0);
        @(negedge clk);
        check("R5 ack_n after release", int'(ack_n), 1);
        repeat (4) @(negedge clk);

        done = 1'b1;
        finish_run();
    end

endmodule